// File: doc/BRIEF.md
# Multi-width flag ALU

This block is the arithmetic and logic stage of a 32-bit integer datapath. It has no registers. It takes two source operands, one from the A bus and one from the B bus, a 3-bit operation code, a select that picks which operand the pass mode forwards, and a carry input. It drives the result bus C and a set of condition flags.

The flags report carry and zero at three widths at the same time: the low byte, the low halfword and the full word. Byte, halfword and word instructions can therefore use the same datapath. The sequencer reads whichever pair of flags matches the width of the instruction, and no separate narrow adder is needed.

The two subtract forms reuse the adder. The B operand is inverted, and the value fed into the carry chain is chosen by the operation code. A subtract that does not borrow leaves the word carry at 1.

Top module: `flag_alu`

## Requirements
- R1: With `op_mode` = 3'b000 and `pass_sel_b` = 0, `res_c` equals `opnd_a`.
- R2: With `op_mode` = 3'b000 and `pass_sel_b` = 1, `res_c` equals `opnd_b`.
- R3: Codes 3'b001, 3'b010 and 3'b011 give the bitwise AND, OR and XOR of `opnd_a` and `opnd_b`, in that order.
- R4: Code 3'b100 gives `opnd_a` + `opnd_b` modulo 2^32, and `cin` has no effect on the result or on the flags.
- R5: Code 3'b101 gives `opnd_a` + `opnd_b` + `cin` modulo 2^32.
- R6: Code 3'b110 gives `opnd_a` + NOT `opnd_b` + 1 modulo 2^32, and `cin` has no effect. Equal operands give a zero result with `cout_w32` = 1.
- R7: Code 3'b111 gives `opnd_a` + NOT `opnd_b` + `cin` modulo 2^32.
- R8: In the four arithmetic codes, `cout_w8`, `cout_w16` and `cout_w32` are the carries out of bit 7, bit 15 and bit 31 of one shared carry chain.
- R9: `zero_w8`, `zero_w16` and `zero_w32` are 1 exactly when result bits [7:0], [15:0] and [31:0] respectively are all zero. This holds in every mode.
- R10: In the pass mode and in the three logic codes, all three carry outputs are 0.
- R11: `pass_sel_b` has no effect in any code other than 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | Operand from the A bus |
| opnd_b | input | 32 | Operand from the B bus |
| op_mode | input | 3 | Operation code |
| pass_sel_b | input | 1 | In pass mode, 1 forwards B and 0 forwards A |
| cin | input | 1 | Carry input for add-with-carry and subtract-with-borrow |
| res_c | output | 32 | Result to the C bus |
| cout_w8 | output | 1 | Carry out of bit 7 |
| cout_w16 | output | 1 | Carry out of bit 15 |
| cout_w32 | output | 1 | Carry out of bit 31 |
| zero_w8 | output | 1 | Result bits [7:0] are all zero |
| zero_w16 | output | 1 | Result bits [15:0] are all zero |
| zero_w32 | output | 1 | Result bits [31:0] are all zero |

## Verification
The embedded assertions check the following on every evaluation:
- each carry-chain segment agrees with its own sum bit through the full-adder relation;
- the three zero flags nest by width;
- carries stay low outside the arithmetic codes;
- pass mode forwards the selected operand;
- subtracting equal operands gives zero with the word carry set.

Other behaviours can only be shown by the bench's scenarios against an independent width-by-width model:
- the correct value of each operation;
- that `cin` has no effect on plain add and subtract;
- that `pass_sel_b` has no effect outside pass mode;
- that the byte and halfword carries tap the right bits, using operands that ripple carries across the 8-bit and 16-bit boundaries.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    localparam int DATA_W = 32;
    localparam int SEG_W  = 8;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int NSEG   = DATA_W / SEG_W;

    typedef enum logic [2:0] {
        OP_PASS = 3'b000,
        OP_AND  = 3'b001,
        OP_OR   = 3'b010,
        OP_XOR  = 3'b011,
        OP_ADD  = 3'b100,
        OP_ADC  = 3'b101,
        OP_SUB  = 3'b110,
        OP_SBB  = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic arith;
        logic invert_b;
        logic use_cin;
    } adder_ctl_t;

    typedef struct packed {
        logic w32;
        logic w16;
        logic w8;
    } width_flags_t;

    function automatic adder_ctl_t decode_op(input alu_op_e op);
        adder_ctl_t c;
        c.arith    = op[2];
        c.invert_b = op[2] & op[1];
        c.use_cin  = op[2] & op[0];
        return c;
    endfunction

    function automatic logic chain_seed(input adder_ctl_t c, input logic cin);
        logic s;
        if (c.use_cin) s = cin;
        else           s = c.invert_b;
        return s;
    endfunction

endpackage

// File: rtl/flag_alu_adder.sv
module flag_alu_adder
    import flag_alu_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int SW    = SEG_W,
    parameter int BW    = BYTE_W,
    parameter int HW    = HALF_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         invert_b,
    input  logic         seed,
    output logic [W-1:0] sum,
    output logic         cout_b,
    output logic         cout_h,
    output logic         cout_w
);
    localparam int NS    = W / SW;
    localparam int TAP_B = BW / SW;
    localparam int TAP_H = HW / SW;

    logic [W-1:0] b_eff;
    logic [NS:0]  chain;

    assign b_eff    = invert_b ? ~b : b;
    assign chain[0] = seed;

    for (genvar g = 0; g < NS; g++) begin : g_seg
        logic [SW:0] part;
        assign part = {1'b0, a[g*SW +: SW]} + {1'b0, b_eff[g*SW +: SW]}
                    + {{SW{1'b0}}, chain[g]};
        assign sum[g*SW +: SW] = part[SW-1:0];
        assign chain[g+1]      = part[SW];

        // R8: segment carry matches full-adder relation at the segment's top bit
        always_comb begin
            a_r8_seg_carry: assert (chain[g+1] ==
                ((a[g*SW+SW-1] & b_eff[g*SW+SW-1]) |
                 ((a[g*SW+SW-1] ^ b_eff[g*SW+SW-1]) & ~sum[g*SW+SW-1])));
        end
    end

    assign cout_b = chain[TAP_B];
    assign cout_h = chain[TAP_H];
    assign cout_w = chain[NS];

endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
    import flag_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [2:0]   op,
    input  logic         sel_b,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    alu_op_e op_e;
    assign op_e = alu_op_e'(op);

    always_comb begin
        unique case (op_e)
            OP_PASS: y = sel_b ? b : a;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/flag_alu_flags.sv
module flag_alu_flags
    import flag_alu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int BW = BYTE_W,
    parameter int HW = HALF_W
) (
    input  logic [W-1:0]  result,
    input  logic          arith,
    input  width_flags_t  chain_cy,
    output width_flags_t  carry,
    output width_flags_t  zero
);
    always_comb begin
        zero.w8  = ~|result[BW-1:0];
        zero.w16 = ~|result[HW-1:0];
        zero.w32 = ~|result;
        carry    = arith ? chain_cy : '0;
    end

    // R9: a zero wide field implies its narrower fields are zero
    always_comb begin
        a_r9_zero_nesting: assert ((!zero.w32 || zero.w16) && (!zero.w16 || zero.w8));
    end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int SW = SEG_W,
    parameter int BW = BYTE_W,
    parameter int HW = HALF_W
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [2:0]   op_mode,
    input  logic         pass_sel_b,
    input  logic         cin,
    output logic [W-1:0] res_c,
    output logic         cout_w8,
    output logic         cout_w16,
    output logic         cout_w32,
    output logic         zero_w8,
    output logic         zero_w16,
    output logic         zero_w32
);
    adder_ctl_t   ctl;
    logic         seed;
    logic [W-1:0] sum;
    logic [W-1:0] logic_y;
    width_flags_t chain_cy;
    width_flags_t carry;
    width_flags_t zero;

    assign ctl  = decode_op(alu_op_e'(op_mode));
    assign seed = chain_seed(ctl, cin);

    flag_alu_adder #(.W(W), .SW(SW), .BW(BW), .HW(HW)) u_adder (
        .a        (opnd_a),
        .b        (opnd_b),
        .invert_b (ctl.invert_b),
        .seed     (seed),
        .sum      (sum),
        .cout_b   (chain_cy.w8),
        .cout_h   (chain_cy.w16),
        .cout_w   (chain_cy.w32)
    );

    flag_alu_logic #(.W(W)) u_logic (
        .op    (op_mode),
        .sel_b (pass_sel_b),
        .a     (opnd_a),
        .b     (opnd_b),
        .y     (logic_y)
    );

    assign res_c = ctl.arith ? sum : logic_y;

    flag_alu_flags #(.W(W), .BW(BW), .HW(HW)) u_flags (
        .result   (res_c),
        .arith    (ctl.arith),
        .chain_cy (chain_cy),
        .carry    (carry),
        .zero     (zero)
    );

    assign cout_w8  = carry.w8;
    assign cout_w16 = carry.w16;
    assign cout_w32 = carry.w32;
    assign zero_w8  = zero.w8;
    assign zero_w16 = zero.w16;
    assign zero_w32 = zero.w32;

    always_comb begin
        // R1
        a_r1_pass_a: assert (!(op_mode == 3'b000 && !pass_sel_b) || res_c == opnd_a);
        // R2
        a_r2_pass_b: assert (!(op_mode == 3'b000 && pass_sel_b) || res_c == opnd_b);
        // R10
        a_r10_no_carry_logic: assert (op_mode[2] || !(cout_w8 | cout_w16 | cout_w32));
        // R6
        a_r6_sub_equal: assert (!(op_mode == 3'b110 && opnd_a == opnd_b) ||
                                (zero_w32 && cout_w32));
    end

endmodule

// File: tb/test_flag_alu.sv
module test_flag_alu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a, b;
    logic [2:0]  mode;
    logic        sel, cin;
    logic [31:0] res;
    logic        c8, c16, c32, z8, z16, z32;
    int          n_checks = 0;
    int          n_fail   = 0;
    int          cycles   = 0;

    always #2 clk = ~clk;

    flag_alu i_flag_alu (
        .opnd_a     (a),
        .opnd_b     (b),
        .op_mode    (mode),
        .pass_sel_b (sel),
        .cin        (cin),
        .res_c      (res),
        .cout_w8    (c8),
        .cout_w16   (c16),
        .cout_w32   (c32),
        .zero_w8    (z8),
        .zero_w16   (z16),
        .zero_w32   (z32)
    );

    // Reference: carries computed separately at each width
    task automatic ref_model(input logic [31:0] ra, input logic [31:0] rb,
                             input logic [2:0] m, input logic s, input logic ci,
                             output logic [37:0] exp_v);
        logic [31:0] r;
        logic [31:0] be;
        logic        c0, k8, k16, k32;
        logic [8:0]  p8;
        logic [16:0] p16;
        logic [32:0] p32;
        k8 = 0; k16 = 0; k32 = 0;
        if (m[2]) begin
            be  = m[1] ? ~rb : rb;
            c0  = m[0] ? ci : m[1];
            p8  = {1'b0, ra[7:0]}  + {1'b0, be[7:0]}  + {8'd0, c0};
            p16 = {1'b0, ra[15:0]} + {1'b0, be[15:0]} + {16'd0, c0};
            p32 = {1'b0, ra}       + {1'b0, be}       + {32'd0, c0};
            r = p32[31:0]; k8 = p8[8]; k16 = p16[16]; k32 = p32[32];
        end else begin
            case (m[1:0])
                2'b00:   r = s ? rb : ra;
                2'b01:   r = ra & rb;
                2'b10:   r = ra | rb;
                default: r = ra ^ rb;
            endcase
        end
        exp_v = {r, k8, k16, k32, (r[7:0] == 0), (r[15:0] == 0), (r == 0)};
    endtask

    task automatic check_vec(input logic [31:0] ta, input logic [31:0] tb_,
                             input logic [2:0] m, input logic s, input logic ci,
                             input string req);
        logic [37:0] exp_v, act_v;
        @(negedge clk);
        a = ta; b = tb_; mode = m; sel = s; cin = ci;
        #1;
        ref_model(ta, tb_, m, s, ci, exp_v);
        act_v = {res, c8, c16, c32, z8, z16, z32};
        n_checks++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s mode=%b a=%h b=%h sel=%b cin=%b actual=%h expected=%h",
                     req, m, ta, tb_, s, ci, act_v, exp_v);
        end
    endtask

    task automatic t_reset_state();
        // R9 R1: all-zero inputs give zero result, all zero flags set
        check_vec(32'h0, 32'h0, 3'b000, 1'b0, 1'b0, "R9 reset state");
    endtask

    task automatic t_pass();
        check_vec(32'hDEADBEEF, 32'h12345678, 3'b000, 1'b0, 1'b1, "R1 pass A");
        check_vec(32'hDEADBEEF, 32'h12345678, 3'b000, 1'b1, 1'b0, "R2 pass B");
        check_vec(32'h00000000, 32'hFFFFFFFF, 3'b000, 1'b1, 1'b1, "R2 pass B ones");
    endtask

    task automatic t_logic();
        for (int m = 1; m < 4; m++) begin
            check_vec(32'hF0F0_A5A5, 32'hFF00_5A0F, 3'(m), 1'b0, 1'b0, "R3 logic");
            check_vec(32'hF0F0_A5A5, 32'hFF00_5A0F, 3'(m), 1'b1, 1'b1, "R11 sel ignored");
            check_vec(32'hFFFFFFFF, 32'hFFFFFFFF, 3'(m), 1'b0, 1'b1, "R10 no carry");
        end
    endtask

    task automatic t_add();
        check_vec(32'h0000_1234, 32'h0000_0001, 3'b100, 1'b0, 1'b1, "R4 add cin ignored");
        check_vec(32'hFFFF_FFFF, 32'h0000_0001, 3'b100, 1'b1, 1'b1, "R4 add wrap R11");
        check_vec(32'h7FFF_FFFF, 32'h0000_0001, 3'b101, 1'b0, 1'b1, "R5 adc with cin");
        check_vec(32'hFFFF_FFFF, 32'h0000_0000, 3'b101, 1'b0, 1'b1, "R5 adc ripple");
    endtask

    task automatic t_sub();
        check_vec(32'h1234_5678, 32'h1234_5678, 3'b110, 1'b0, 1'b0, "R6 sub equal");
        check_vec(32'h0000_0000, 32'h0000_0001, 3'b110, 1'b0, 1'b1, "R6 sub borrow");
        check_vec(32'h0000_0005, 32'h0000_0003, 3'b111, 1'b0, 1'b0, "R7 sbb borrow in");
        check_vec(32'h0000_0005, 32'h0000_0005, 3'b111, 1'b1, 1'b1, "R7 sbb no borrow");
    endtask

    task automatic t_taps();
        check_vec(32'h0000_00FF, 32'h0000_0001, 3'b100, 1'b0, 1'b0, "R8 byte carry only");
        check_vec(32'h0000_FFFF, 32'h0000_0001, 3'b100, 1'b0, 1'b0, "R8 half carry");
        check_vec(32'h0000_0080, 32'h0000_0080, 3'b100, 1'b0, 1'b0, "R8 byte carry R9");
        check_vec(32'h0001_0000, 32'h0000_0000, 3'b100, 1'b0, 1'b0, "R9 low half zero");
        check_vec(32'h0000_0100, 32'h0000_0000, 3'b001, 1'b0, 1'b0, "R9 low byte zero");
    endtask

    task automatic t_random();
        for (int i = 0; i < 400; i++) begin
            check_vec($urandom, $urandom, 3'($urandom_range(0, 7)), 1'($urandom),
                      1'($urandom), "R8 random all modes");
        end
    endtask

    initial begin
        a = 0; b = 0; mode = 0; sel = 0; cin = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_pass();
        t_logic();
        t_add();
        t_sub();
        t_taps();
        t_random();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule